// File: doc/BRIEF.md
# Timer-Driven Interrupt Dispatch Unit

This unit sits next to the step logic of a simple in-order processor and decides, before every instruction fetch, whether the processor must take an interrupt trap instead. It keeps a free-running retired-instruction counter, a compare register and an eight-line pending-interrupt vector. Each retired instruction advances the counter. When the counter value before that increment equals the compare register, timer line 7 becomes pending.

The processor supplies the global trap-enable bit and the eight-bit interrupt mask. The mask is the status-register field at bits 15:8, already shifted down so that mask bit i lines up with pending bit i. When the processor requests a fetch, the unit ANDs the pending vector with the mask. If the result is nonzero and traps are enabled, it raises a one-cycle trap strobe together with a cause code for the lowest-numbered enabled line. It then holds back the fetch grant for that cycle. Software can write the counter, the compare register and the pending vector through a simple write port. Pending bits stay set until software clears them.

Top module: `timer_irq_unit`

## Requirements
- R1: While reset is held, count_o, compare_o and pending_o are all zero.
- R2: trap_o is high only in a cycle where fetch_req_i is high, trap_en_i is high and (pending_o AND irq_mask_i) is nonzero. In every such cycle trap_o is high. Mask bit i enables pending line i.
- R3: When several enabled lines are pending at once, the trap selects the one with the lowest index.
- R4: While trap_o is high, cause_o equals 16 plus the index of the selected line.
- R5: On a cycle with retire_i high, if count_o equals compare_o before the edge, pending bit 7 is set after the edge. All other pending bits keep their values.
- R6: Every retire_i pulse advances count_o by exactly one. 0xFFFFFFFF wraps to 0, and the wrap by itself changes no pending bit.
- R7: fetch_go_o equals fetch_req_i AND NOT trap_o, so no fetch is granted in a trap cycle.
- R8: With wr_en_i high, wr_sel_i selects the target: 0 writes count from wr_data_i, 1 writes compare, 2 writes pending from wr_data_i[7:0], and 3 changes nothing. A count write wins over a same-cycle retire increment. The timer match in that cycle still uses the old count.
- R9: A pending write replaces all eight bits. If a timer match happens in the same cycle, bit 7 is still set after the write.
- R10: Taking a trap does not clear any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retired this cycle |
| fetch_req_i | input | 1 | Processor wants to fetch this cycle |
| trap_en_i | input | 1 | Global trap-enable status bit |
| irq_mask_i | input | 8 | Interrupt mask (status bits 15:8, aligned to line 0) |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 2 | Write target: 0 count, 1 compare, 2 pending, 3 none |
| wr_data_i | input | 32 | Software write data |
| trap_o | output | 1 | Trap request instead of fetch |
| cause_o | output | 8 | Trap cause code, valid with trap_o |
| fetch_go_o | output | 1 | Fetch may proceed this cycle |
| count_o | output | 32 | Current counter value |
| compare_o | output | 32 | Current compare value |
| pending_o | output | 8 | Current pending vector |

## Verification
A software write to the pending vector and a timer match from a retiring instruction can land in the same cycle. In that cycle bit 7 must survive the replacement of the other bits. The bench provokes this on purpose: it loads the counter and the compare register with equal values, then issues a pending write together with a retire pulse. It also mixes random pending writes with retires while the compare register is kept close to the counter. The resulting vector is judged against a bench model that first applies the write and then ORs in the match taken from the pre-increment count.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CNT_W      = 32;
  localparam int unsigned NUM_IRQ    = 8;
  localparam int unsigned TIMER_LINE = 7;
  localparam int unsigned CAUSE_BASE = 16;
  localparam int unsigned CAUSE_W    = 8;

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             cnt_we_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;

  // match on pre-increment value
  assign match_o = retire_i && (count_q == cmp_q);

  always_comb begin
    count_d = count_q;
    if (cnt_we_i)      count_d = wdata_i;
    else if (retire_i) count_d = count_q + ONE;
  end

  always_comb begin
    cmp_d = cmp_q;
    if (cmp_we_i) cmp_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      count_q <= count_d;
      cmp_q   <= cmp_d;
    end
  end

  assign count_o   = count_q;
  assign compare_o = cmp_q;
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_IRQ    = 8,
  parameter int unsigned TIMER_LINE = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  input  logic               timer_hit_i,
  output logic [NUM_IRQ-1:0] pending_o
);
  logic [NUM_IRQ-1:0] pend_q, pend_d, hit_vec;

  always_comb begin
    hit_vec = '0;
    hit_vec[TIMER_LINE] = timer_hit_i;
  end

  // software write first, timer hit ORed on top
  always_comb begin
    pend_d = we_i ? wdata_i : pend_q;
    pend_d = pend_d | hit_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NUM_IRQ    = 8,
  parameter int unsigned CAUSE_W    = 8,
  parameter int unsigned CAUSE_BASE = 16
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NUM_IRQ-1:0] seen;
  logic [NUM_IRQ-1:0] grant;

  // lowest index wins: grant where no lower line requests
  assign seen[0]  = req_i[0];
  assign grant[0] = req_i[0];
  for (genvar g = 1; g < NUM_IRQ; g++) begin : g_chain
    assign seen[g]  = seen[g-1] | req_i[g];
    assign grant[g] = req_i[g] & ~seen[g-1];
  end

  assign any_o = seen[NUM_IRQ-1];

  always_comb begin
    cause_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant[i]) cause_o = cause_o | CAUSE_W'(CAUSE_BASE + i);
    end
  end
endmodule

// File: rtl/timer_irq_unit.sv
module timer_irq_unit
  import irq_pkg::*;
#(
  parameter int unsigned CNT_W      = irq_pkg::CNT_W,
  parameter int unsigned NUM_IRQ    = irq_pkg::NUM_IRQ,
  parameter int unsigned TIMER_LINE = irq_pkg::TIMER_LINE,
  parameter int unsigned CAUSE_BASE = irq_pkg::CAUSE_BASE,
  parameter int unsigned CAUSE_W    = irq_pkg::CAUSE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               retire_i,
  input  logic               fetch_req_i,
  input  logic               trap_en_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               fetch_go_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   compare_o,
  output logic [NUM_IRQ-1:0] pending_o
);
  logic               cnt_we, cmp_we, pend_we;
  logic               timer_hit;
  logic [NUM_IRQ-1:0] enabled;
  logic               any_irq;
  logic [CAUSE_W-1:0] sel_cause;

  assign cnt_we  = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign cmp_we  = wr_en_i && (wr_sel_i == SEL_COMPARE);
  assign pend_we = wr_en_i && (wr_sel_i == SEL_PENDING);

  irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .retire_i  (retire_i),
    .cnt_we_i  (cnt_we),
    .cmp_we_i  (cmp_we),
    .wdata_i   (wr_data_i),
    .count_o   (count_o),
    .compare_o (compare_o),
    .match_o   (timer_hit)
  );

  irq_pending #(.NUM_IRQ(NUM_IRQ), .TIMER_LINE(TIMER_LINE)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (pend_we),
    .wdata_i     (wr_data_i[NUM_IRQ-1:0]),
    .timer_hit_i (timer_hit),
    .pending_o   (pending_o)
  );

  assign enabled = pending_o & irq_mask_i;

  irq_prio #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W), .CAUSE_BASE(CAUSE_BASE)) u_prio (
    .req_i   (enabled),
    .any_o   (any_irq),
    .cause_o (sel_cause)
  );

  // check precedes fetch; trap suppresses the grant
  assign trap_o     = fetch_req_i && trap_en_i && any_irq;
  assign cause_o    = trap_o ? sel_cause : '0;
  assign fetch_go_o = fetch_req_i && !trap_o;
endmodule

// File: rtl/timer_irq_unit_chk.sv
module timer_irq_unit_chk #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned NUM_IRQ    = 8,
  parameter int unsigned TIMER_LINE = 7,
  parameter int unsigned CAUSE_BASE = 16,
  parameter int unsigned CAUSE_W    = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               retire_i,
  input logic               fetch_req_i,
  input logic               trap_en_i,
  input logic [NUM_IRQ-1:0] irq_mask_i,
  input logic               wr_en_i,
  input logic [1:0]         wr_sel_i,
  input logic [CNT_W-1:0]   wr_data_i,
  input logic               trap_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               fetch_go_o,
  input logic [CNT_W-1:0]   count_o,
  input logic [CNT_W-1:0]   compare_o,
  input logic [NUM_IRQ-1:0] pending_o
);
  logic [NUM_IRQ-1:0] below_sel;
  logic               cnt_wr, pend_wr;

  assign cnt_wr  = wr_en_i && (wr_sel_i == 2'd0);
  assign pend_wr = wr_en_i && (wr_sel_i == 2'd2);

  always_comb begin
    below_sel = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (CAUSE_W'(CAUSE_BASE + i) < cause_o) below_sel[i] = 1'b1;
  end

  always @(posedge clk_i)
    if (!rst_ni)
      assert_reset_clear_R1: assert (count_o == '0 && compare_o == '0 && pending_o == '0);

  assert_trap_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (fetch_req_i && trap_en_i && (pending_o & irq_mask_i) != '0));

  assert_trap_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && trap_en_i && (pending_o & irq_mask_i) != '0) |-> trap_o);

  assert_lowest_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ((pending_o & irq_mask_i & below_sel) == '0));

  assert_cause_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (cause_o >= CAUSE_W'(CAUSE_BASE) && cause_o < CAUSE_W'(CAUSE_BASE + NUM_IRQ)));

  assert_timer_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && count_o == compare_o) |=> pending_o[TIMER_LINE]);

  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !cnt_wr) |=> (count_o == $past(count_o) + 1'b1));

  assert_no_fetch_on_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_go_o == (fetch_req_i && !trap_o));

  assert_count_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (count_o == $past(wr_data_i)));

  assert_pending_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_wr |=> ((pending_o & $past(pending_o)) == $past(pending_o)));
endmodule

bind timer_irq_unit timer_irq_unit_chk #(
  .CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ), .TIMER_LINE(TIMER_LINE),
  .CAUSE_BASE(CAUSE_BASE), .CAUSE_W(CAUSE_W)
) u_chk (.*);

// File: tb/tb_timer_irq_unit.sv
module tb_timer_irq_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire_i = 1'b0, fetch_req_i = 1'b0, trap_en_i = 1'b0;
  logic [7:0]  irq_mask_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        trap_o, fetch_go_o;
  logic [7:0]  cause_o, pending_o;
  logic [31:0] count_o, compare_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt = '0, m_cmp = '0;
  logic [7:0]  m_pend = '0;

  always #5 clk_i = ~clk_i;

  timer_irq_unit dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_trap(input logic fet, input logic en, input logic [7:0] msk);
    return fet && en && ((m_pend & msk) != 8'h00);
  endfunction

  function automatic logic [7:0] exp_cause(input logic [7:0] msk);
    logic [7:0] v = m_pend & msk;
    for (int i = 7; i >= 0; i--) if (v[i]) exp_cause = 8'(16 + i);
    if (v == 8'h00) exp_cause = 8'h00;
  endfunction

  // inputs at negedge; comb check before edge, state check after edge
  task automatic cyc(input logic ret, input logic fet, input logic en, input logic [7:0] msk,
                     input logic we, input logic [1:0] sel, input logic [31:0] dat);
    logic t, hit;
    retire_i = ret; fetch_req_i = fet; trap_en_i = en; irq_mask_i = msk;
    wr_en_i = we; wr_sel_i = sel; wr_data_i = dat;
    #1;
    t = exp_trap(fet, en, msk);
    chk("R2 trap", {31'b0, trap_o}, {31'b0, t});
    chk("R7 fetch_go", {31'b0, fetch_go_o}, {31'b0, fet && !t});
    if (t) chk("R3/R4 cause", {24'b0, cause_o}, {24'b0, exp_cause(msk)});
    hit = ret && (m_cnt == m_cmp);
    if (we && sel == 2'd0) m_cnt = dat; else if (ret) m_cnt = m_cnt + 1;
    if (we && sel == 2'd1) m_cmp = dat;
    if (we && sel == 2'd2) m_pend = dat[7:0];
    if (hit) m_pend[7] = 1'b1;
    @(posedge clk_i); #1;
    chk("R6/R8 count", count_o, m_cnt);
    chk("R8 compare", compare_o, m_cmp);
    chk("R5/R9/R10 pending", {24'b0, pending_o}, {24'b0, m_pend});
    @(negedge clk_i);
    retire_i = 1'b0; fetch_req_i = 1'b0; wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 count reset", count_o, 32'h0);
    chk("R1 compare reset", compare_o, 32'h0);
    chk("R1 pending reset", {24'b0, pending_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 gating and mask alignment
    cyc(0, 0, 0, 8'h00, 1, 2'd2, 32'h05);
    cyc(0, 1, 1, 8'h00, 0, 2'd0, 0);
    cyc(0, 1, 1, 8'h04, 0, 2'd0, 0);
    cyc(0, 1, 0, 8'hFF, 0, 2'd0, 0);
    // R3 lowest wins, R10 no auto clear
    cyc(0, 0, 0, 8'h00, 1, 2'd2, 32'h0A);
    cyc(0, 1, 1, 8'hFF, 0, 2'd0, 0);
    chk("R10 pending kept after trap", {24'b0, pending_o}, 32'h0A);
    cyc(0, 1, 1, 8'hFF, 0, 2'd0, 0);
    // R5 timer match
    cyc(0, 0, 0, 0, 1, 2'd0, 32'd10);
    cyc(0, 0, 0, 0, 1, 2'd1, 32'd10);
    cyc(0, 0, 0, 0, 1, 2'd2, 32'h01);
    cyc(1, 0, 0, 0, 0, 2'd0, 0);
    chk("R5 timer bit set", {24'b0, pending_o}, 32'h81);
    cyc(0, 1, 1, 8'h80, 0, 2'd0, 0);
    // R6 wrap
    cyc(0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 0, 1, 2'd1, 32'd5);
    cyc(1, 0, 0, 0, 0, 2'd0, 0);
    chk("R6 wrap count", count_o, 32'h0);
    chk("R6 wrap pending", {24'b0, pending_o}, 32'h81);
    // R8 write beats increment; select 3 ignored
    cyc(1, 0, 0, 0, 1, 2'd0, 32'h55);
    chk("R8 count write wins", count_o, 32'h55);
    cyc(0, 0, 0, 0, 1, 2'd3, 32'hDEAD_BEEF);
    chk("R8 sel3 count", count_o, 32'h55);
    chk("R8 sel3 compare", compare_o, 32'd5);
    chk("R8 sel3 pending", {24'b0, pending_o}, 32'h81);
    // R9 pending write with match
    cyc(0, 0, 0, 0, 1, 2'd0, 32'd20);
    cyc(0, 0, 0, 0, 1, 2'd1, 32'd20);
    cyc(1, 0, 0, 0, 1, 2'd2, 32'h03);
    chk("R9 write plus match", {24'b0, pending_o}, 32'h83);

    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  sel = 2'($urandom);
      logic [31:0] dat = $urandom;
      if (sel == 2'd1) dat = m_cnt + ($urandom % 4);
      if (sel == 2'd0 && ($urandom % 4) == 0) dat = 32'hFFFF_FFFE;
      cyc(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
          ($urandom % 6) == 0, sel, dat);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule